// File: doc/BRIEF.md
# Base Address Register Size Prober

This block runs, in hardware, the host-side sequence that finds how much address space a device's memory base address register asks for. A pulse on the start input latches the configuration address of the register. The block then drives a simple configuration access port: request, write enable, address, write data, read data and a one-cycle done handshake. It reads and keeps the current contents of the register, fills it with all ones and reads it back. It then writes the kept value back again, so the register is left as it was found.

The value read back after the all-ones write holds the answer. The writable address bits show the size, and the low bits hold the flags. The block clears the four flag bits, inverts what is left and adds one, which gives the region size in bytes. It reports this size with the space indicator, the two-bit memory type and the prefetchable flag. A register with no writable address bits is reported as unimplemented. An I/O register, or a memory register whose type field is not 32-bit, is reported as unsupported with no size.

Top module: `bar_size_prober`

## Requirements
- R1: During and right after reset, cfg_req_o, done_o and busy_o are 0, and size_o and all result flags are 0.
- R2: A probe makes exactly four accesses, all to the latched address, in this order: a read, a write of all ones, a read, and a write of the value returned by the first read.
- R3: Each access keeps cfg_req_o, cfg_we_o, cfg_addr_o and cfg_wdata_o unchanged until a cycle with cfg_done_i high. The block moves on only after that cycle, whatever the port latency.
- R4: For a memory register with type bits 2:1 equal to 00, size_o equals the bitwise inverse of the read-back value with bits 3:0 cleared, plus one.
- R5: io_space_o reports bit 0 of the read-back value, mem_type_o reports bits 2:1 and prefetch_o reports bit 3.
- R6: When bits 31:4 of the read-back value are all zero and the type is supported, unimpl_o is 1 and size_o is 0.
- R7: When bit 0 is 1 or bits 2:1 are not 00, unsupported_o is 1 and size_o is 0. The original value is still written back.
- R8: done_o is high for exactly one cycle per probe. size_o and the flags change only in the cycle in which done_o is high, and keep their values until the next probe completes.
- R9: A start pulse while busy_o is 1 is ignored: the address, the access sequence and the number of done pulses are the same as without it.
- R10: busy_o is 1 from the cycle after an accepted start up to and including the done_o cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Starts a probe when idle |
| bar_addr_i | input | ADDR_W | Configuration address of the register to probe |
| cfg_req_o | output | 1 | Access request, held until done |
| cfg_we_o | output | 1 | 1 = write access, 0 = read access |
| cfg_addr_o | output | ADDR_W | Access address |
| cfg_wdata_o | output | DATA_W | Write data |
| cfg_rdata_i | input | DATA_W | Read data, valid with cfg_done_i |
| cfg_done_i | input | 1 | One-cycle completion of the current access |
| busy_o | output | 1 | Probe in progress |
| done_o | output | 1 | One-cycle completion pulse |
| size_o | output | DATA_W | Region size in bytes, 0 when not sizable |
| mem_type_o | output | 2 | Read-back bits 2:1 |
| prefetch_o | output | 1 | Read-back bit 3 |
| io_space_o | output | 1 | Read-back bit 0 |
| unimpl_o | output | 1 | No writable address bits |
| unsupported_o | output | 1 | I/O or non-32-bit memory register |

## Verification
Clocked assertions watch the port-holding rule, the single-cycle completion pulse, the stability of the results outside that pulse, the fixed address during a probe, and a zero size whenever a result is flagged unimplemented or unsupported. The order of the four accesses, the size arithmetic for several masks, the decoded flags, the final register contents and the effect of a start pulse during a probe can only be shown by the bench. It does this with a register model that answers the port with a chosen latency.

// File: rtl/bar_probe_pkg.sv
package bar_probe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAVE_RD,
    ST_ONES_WR,
    ST_PROBE_RD,
    ST_RESTORE_WR,
    ST_DONE
  } probe_state_e;

  localparam int unsigned FLAG_BITS = 4;
endpackage

// File: rtl/bar_probe_fsm.sv
module bar_probe_fsm
  import bar_probe_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] bar_addr_i,
  output logic              cfg_req_o,
  output logic              cfg_we_o,
  output logic [ADDR_W-1:0] cfg_addr_o,
  output logic [DATA_W-1:0] cfg_wdata_o,
  input  logic [DATA_W-1:0] cfg_rdata_i,
  input  logic              cfg_done_i,
  output logic [DATA_W-1:0] probe_val_o,
  output logic              capture_o,
  output logic              busy_o,
  output logic              done_o
);
  probe_state_e state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] saved_q, probe_q;
  logic addr_en, saved_en, probe_en;

  assign addr_en  = (state_q == ST_IDLE) && start_i;
  assign saved_en = (state_q == ST_SAVE_RD) && cfg_done_i;
  assign probe_en = (state_q == ST_PROBE_RD) && cfg_done_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:       if (start_i)    state_d = ST_SAVE_RD;
      ST_SAVE_RD:    if (cfg_done_i) state_d = ST_ONES_WR;
      ST_ONES_WR:    if (cfg_done_i) state_d = ST_PROBE_RD;
      ST_PROBE_RD:   if (cfg_done_i) state_d = ST_RESTORE_WR;
      ST_RESTORE_WR: if (cfg_done_i) state_d = ST_DONE;
      ST_DONE:                       state_d = ST_IDLE;
      default:                       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      saved_q <= '0;
      probe_q <= '0;
    end else begin
      state_q <= state_d;
      if (addr_en)  addr_q  <= bar_addr_i;
      if (saved_en) saved_q <= cfg_rdata_i;
      if (probe_en) probe_q <= cfg_rdata_i;
    end
  end

  always_comb begin
    cfg_req_o   = 1'b0;
    cfg_we_o    = 1'b0;
    cfg_wdata_o = '0;
    case (state_q)
      ST_SAVE_RD, ST_PROBE_RD: cfg_req_o = 1'b1;
      ST_ONES_WR: begin
        cfg_req_o   = 1'b1;
        cfg_we_o    = 1'b1;
        cfg_wdata_o = '1;
      end
      ST_RESTORE_WR: begin
        cfg_req_o   = 1'b1;
        cfg_we_o    = 1'b1;
        cfg_wdata_o = saved_q;
      end
      default: ;
    endcase
  end

  assign cfg_addr_o  = addr_q;
  assign probe_val_o = probe_q;
  assign capture_o   = (state_q == ST_RESTORE_WR) && cfg_done_i;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_o && !cfg_done_i) |=> (cfg_req_o && $stable(cfg_we_o) &&
      $stable(cfg_addr_o) && $stable(cfg_wdata_o)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_addr_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> $stable(cfg_addr_o));
endmodule

// File: rtl/bar_probe_decode.sv
module bar_probe_decode
  import bar_probe_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] probe_i,
  output logic [DATA_W-1:0] size_o,
  output logic [1:0]        mem_type_o,
  output logic              prefetch_o,
  output logic              io_space_o,
  output logic              unimpl_o,
  output logic              unsupported_o
);
  localparam logic [DATA_W-1:0] FLAG_MASK = DATA_W'((1 << FLAG_BITS) - 1);

  logic [DATA_W-1:0] addr_bits;

  assign addr_bits     = probe_i & ~FLAG_MASK;
  assign io_space_o    = probe_i[0];
  assign mem_type_o    = probe_i[2:1];
  assign prefetch_o    = probe_i[3];
  assign unsupported_o = probe_i[0] || (probe_i[2:1] != 2'b00);
  assign unimpl_o      = !unsupported_o && (addr_bits == '0);
  assign size_o        = (unsupported_o || unimpl_o) ? '0 : (~addr_bits + DATA_W'(1));
endmodule

// File: rtl/bar_probe_result.sv
module bar_probe_result #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] size_i,
  input  logic [1:0]        mem_type_i,
  input  logic              prefetch_i,
  input  logic              io_space_i,
  input  logic              unimpl_i,
  input  logic              unsupported_i,
  output logic [DATA_W-1:0] size_o,
  output logic [1:0]        mem_type_o,
  output logic              prefetch_o,
  output logic              io_space_o,
  output logic              unimpl_o,
  output logic              unsupported_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_o        <= '0;
      mem_type_o    <= '0;
      prefetch_o    <= 1'b0;
      io_space_o    <= 1'b0;
      unimpl_o      <= 1'b0;
      unsupported_o <= 1'b0;
    end else if (capture_i) begin
      size_o        <= size_i;
      mem_type_o    <= mem_type_i;
      prefetch_o    <= prefetch_i;
      io_space_o    <= io_space_i;
      unimpl_o      <= unimpl_i;
      unsupported_o <= unsupported_i;
    end
  end

  assert_unsup_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    unsupported_o |-> (size_o == '0 && !unimpl_o));

  assert_unimpl_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    unimpl_o |-> (size_o == '0));
endmodule

// File: rtl/bar_size_prober.sv
module bar_size_prober #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] bar_addr_i,
  output logic              cfg_req_o,
  output logic              cfg_we_o,
  output logic [ADDR_W-1:0] cfg_addr_o,
  output logic [DATA_W-1:0] cfg_wdata_o,
  input  logic [DATA_W-1:0] cfg_rdata_i,
  input  logic              cfg_done_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] size_o,
  output logic [1:0]        mem_type_o,
  output logic              prefetch_o,
  output logic              io_space_o,
  output logic              unimpl_o,
  output logic              unsupported_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic [DATA_W-1:0] probe_val, dec_size;
  logic              capture;
  logic [1:0]        dec_type;
  logic              dec_pf, dec_io, dec_unimpl, dec_unsup;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  bar_probe_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n_int), .start_i(start_i), .bar_addr_i(bar_addr_i),
    .cfg_req_o(cfg_req_o), .cfg_we_o(cfg_we_o), .cfg_addr_o(cfg_addr_o),
    .cfg_wdata_o(cfg_wdata_o), .cfg_rdata_i(cfg_rdata_i), .cfg_done_i(cfg_done_i),
    .probe_val_o(probe_val), .capture_o(capture), .busy_o(busy_o), .done_o(done_o)
  );

  bar_probe_decode #(.DATA_W(DATA_W)) u_dec (
    .probe_i(probe_val), .size_o(dec_size), .mem_type_o(dec_type),
    .prefetch_o(dec_pf), .io_space_o(dec_io), .unimpl_o(dec_unimpl),
    .unsupported_o(dec_unsup)
  );

  bar_probe_result #(.DATA_W(DATA_W)) u_res (
    .clk(clk), .rst_n(rst_n_int), .capture_i(capture),
    .size_i(dec_size), .mem_type_i(dec_type), .prefetch_i(dec_pf),
    .io_space_i(dec_io), .unimpl_i(dec_unimpl), .unsupported_i(dec_unsup),
    .size_o(size_o), .mem_type_o(mem_type_o), .prefetch_o(prefetch_o),
    .io_space_o(io_space_o), .unimpl_o(unimpl_o), .unsupported_o(unsupported_o)
  );

  assert_result_steady_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    !done_o |-> ($stable(size_o) && $stable(unsupported_o) && $stable(unimpl_o)));

  assert_busy_done_R10: assert property (@(posedge clk) disable iff (!rst_n_int)
    done_o |-> busy_o);
endmodule

// File: tb/tb_bar_size_prober.sv
module tb_bar_size_prober;
  localparam int DW = 32;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i;
  logic [AW-1:0] bar_addr_i;
  logic cfg_req_o, cfg_we_o, cfg_done_i;
  logic [AW-1:0] cfg_addr_o;
  logic [DW-1:0] cfg_wdata_o, cfg_rdata_i;
  logic busy_o, done_o, prefetch_o, io_space_o, unimpl_o, unsupported_o;
  logic [DW-1:0] size_o;
  logic [1:0] mem_type_o;

  always #2.5 clk = ~clk;

  bar_size_prober #(.DATA_W(DW), .ADDR_W(AW)) dut (.*);

  int checks = 0;
  int errors = 0;

  // register model behind the port
  logic [DW-1:0] reg_val, reg_mask, reg_fixed;
  int lat = 0;
  int acc_n;
  logic          acc_we   [8];
  logic [DW-1:0] acc_data [8];
  logic [AW-1:0] acc_addr [8];
  int done_pulses;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    int cnt;
    cnt = 0;
    cfg_done_i  = 1'b0;
    cfg_rdata_i = '0;
    forever begin
      @(negedge clk);
      if (done_o) done_pulses++;
      if (cfg_done_i) begin
        cfg_done_i = 1'b0;
        cnt = 0;
      end else if (cfg_req_o) begin
        if (cnt >= lat) begin
          if (acc_n < 8) begin
            acc_we[acc_n]   = cfg_we_o;
            acc_data[acc_n] = cfg_we_o ? cfg_wdata_o : reg_val;
            acc_addr[acc_n] = cfg_addr_o;
          end
          acc_n++;
          if (cfg_we_o) reg_val = (cfg_wdata_o & reg_mask) | reg_fixed;
          else          cfg_rdata_i = reg_val;
          cfg_done_i = 1'b1;
        end else cnt++;
      end
    end
  end

  initial begin
    #(5ns * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic pulse_start(input logic [AW-1:0] a);
    @(negedge clk);
    start_i = 1'b1;
    bar_addr_i = a;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    int t;
    t = 0;
    while (!done_o && t < 200) begin
      @(negedge clk);
      t++;
    end
  endtask

  // one probe scenario with full sequence and result checks
  task automatic probe(input string name, input logic [DW-1:0] orig,
                       input logic [DW-1:0] mask, input logic [DW-1:0] fixed,
                       input int latency, input logic [AW-1:0] a,
                       input logic [DW-1:0] exp_size, input bit exp_unimpl,
                       input bit exp_unsup, input bit mid_start);
    logic [DW-1:0] start_val, rb;
    reg_mask  = mask;
    reg_fixed = fixed;
    reg_val   = (orig & mask) | fixed;
    start_val = reg_val;
    rb        = mask | fixed;
    lat       = latency;
    acc_n     = 0;
    done_pulses = 0;
    pulse_start(a);
    chk(busy_o == 1'b1, {name, " R10 busy after start"}, DW'(busy_o), 1);
    if (mid_start) begin
      @(negedge clk);
      start_i = 1'b1;
      bar_addr_i = a ^ 12'hFFF;
      @(negedge clk);
      start_i = 1'b0;
    end
    wait_done();
    chk(done_o == 1'b1, {name, " R8 done seen"}, DW'(done_o), 1);
    chk(busy_o == 1'b1, {name, " R10 busy in done cycle"}, DW'(busy_o), 1);
    chk(acc_n == 4, {name, " R2 access count"}, DW'(acc_n), 4);
    chk(acc_we[0] == 0 && acc_data[0] == start_val, {name, " R2 save read"}, acc_data[0], start_val);
    chk(acc_we[1] == 1 && acc_data[1] == '1, {name, " R2 ones write"}, acc_data[1], '1);
    chk(acc_we[2] == 0 && acc_data[2] == rb, {name, " R2 probe read"}, acc_data[2], rb);
    chk(acc_we[3] == 1 && acc_data[3] == start_val, {name, " R2 restore write"}, acc_data[3], start_val);
    chk(acc_addr[0] == a && acc_addr[3] == a, {name, " R9 address kept"}, DW'(acc_addr[3]), DW'(a));
    chk(reg_val == start_val, {name, " R7 register restored"}, reg_val, start_val);
    chk(size_o == exp_size, {name, " R4 size"}, size_o, exp_size);
    chk(io_space_o == rb[0] && mem_type_o == rb[2:1] && prefetch_o == rb[3],
        {name, " R5 flags"}, {28'd0, prefetch_o, mem_type_o, io_space_o}, DW'(rb[3:0]));
    chk(unimpl_o == exp_unimpl, {name, " R6 unimplemented"}, DW'(unimpl_o), DW'(exp_unimpl));
    chk(unsupported_o == exp_unsup, {name, " R7 unsupported"}, DW'(unsupported_o), DW'(exp_unsup));
    @(negedge clk);
    chk(done_o == 1'b0, {name, " R8 done one cycle"}, DW'(done_o), 0);
    chk(busy_o == 1'b0, {name, " R10 idle after done"}, DW'(busy_o), 0);
    repeat (3) @(negedge clk);
    chk(size_o == exp_size, {name, " R8 size held"}, size_o, exp_size);
    chk(done_pulses == 1, {name, " R9 single done pulse"}, DW'(done_pulses), 1);
  endtask

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    bar_addr_i = '0;
    reg_val = '0; reg_mask = '0; reg_fixed = '0;
    acc_n = 0;
    done_pulses = 0;
    repeat (3) @(negedge clk);
    chk(cfg_req_o == 0 && done_o == 0 && busy_o == 0, "R1 reset outputs", DW'({cfg_req_o, done_o, busy_o}), 0);
    chk(size_o == 0 && !unimpl_o && !unsupported_o, "R1 reset results", size_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cfg_req_o == 0 && busy_o == 0, "R1 idle after reset", DW'({cfg_req_o, busy_o}), 0);

    probe("mem16M",  32'hE2000000, 32'hFF000000, 32'h0, 0, 12'h010, 32'h01000000, 0, 0, 0);
    probe("pf4K",    32'hC0001000, 32'hFFFFF000, 32'h8, 3, 12'h014, 32'h00001000, 0, 0, 0);
    probe("min16",   32'h12345670, 32'hFFFFFFF0, 32'h0, 1, 12'h018, 32'h00000010, 0, 0, 0);
    probe("max2G",   32'h80000000, 32'h80000000, 32'h0, 2, 12'h01C, 32'h80000000, 0, 0, 0);
    probe("unimpl",  32'h0,        32'h0,        32'h0, 1, 12'h020, 32'h0,        1, 0, 0);
    probe("io",      32'h0000E001, 32'hFFFFFF00, 32'h1, 2, 12'h024, 32'h0,        0, 1, 0);
    probe("type64",  32'hF0000004, 32'hFFF00000, 32'h4, 0, 12'h010, 32'h0,        0, 1, 0);
    probe("midstart",32'hD0000000, 32'hFFFF0000, 32'h0, 4, 12'h030, 32'h00010000, 0, 0, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule